// File: doc/BRIEF.md
# Page-Write Load and Commit Controller

This block is the clocked write-control front end of a byte-wide nonvolatile store. An external host drives three active-low strobes (chip select, output enable, write enable) together with a 16-bit address and an 8-bit data byte. The strobes are asynchronous to the block's clock. The block brings them into its clock domain and sees a byte load on the cycle the combined write condition becomes true. The first load opens a page. Each later load adds one byte to a page buffer, but only if its address falls in that same page.

Every accepted load restarts an inactivity window. When a whole window passes with no accepted load, the block raises `busy` and runs a self-timed programming cycle of fixed length. During that cycle it walks the page buffer and copies only the bytes that were loaded into a behavioural register-file array. When the cycle ends, `busy` drops and the block can take a new page. A read strobe returns the stored byte at the presented address. The array holds `ARRAY_BYTES` bytes, and addresses alias modulo that size.

Top module: `page_commit_ctrl`

## Requirements
- R1: A byte load is recognised only while chip select and write enable are both low and output enable is high. With output enable low, or with chip select high, a write-enable pulse loads nothing and starts no programming cycle.
- R2: Address bits 15..7 are the page number and bits 6..0 the byte offset within a 128-byte page. A loaded byte lands at array index equal to the full address modulo `ARRAY_BYTES`.
- R3: Once a page is open, a load whose bits 15..7 differ from the first load's page is discarded and does not restart the inactivity window.
- R4: Loads that each start within the window of the previous accepted load keep the page open with no limit on total phase length. `busy` stays low throughout.
- R5: `busy` rises exactly `WINDOW_CYC` clock cycles after the cycle of the last accepted load. Seen from the pins, that is `SYNC_STAGES + WINDOW_CYC + 1` falling clock edges after write enable is driven low on a falling edge.
- R6: `busy` stays high for exactly `PROG_CYCLES` clock cycles per programming cycle.
- R7: Write strobes while `busy` is high are ignored: they change no array byte and open no new page.
- R8: Only bytes actually loaded are updated. Other bytes of the same page keep their previous contents.
- R9: After reset `busy` is low and every array byte reads as zero.
- R10: `rdata` shows the array byte at `addr` while chip select and output enable are low (synchronised) and write enable is high. Otherwise `rdata` is zero.
- R11: When the same offset is loaded more than once in one page, the last loaded value is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 16 | Byte address: page in 15..7, offset in 6..0 |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Array byte during a read, zero otherwise |
| busy | output | 1 | High during the programming cycle |

## Verification
The hardest case to reach from the pins is an off-page load that arrives while a page is open. It must leave the window untouched. The only visible proof is that `busy` rises on the same cycle it would have risen with no off-page load at all. The stimulus therefore times the first load from its write-enable edge and injects an off-page load partway through the window. It then checks that the commit point falls on the exact edge computed from the first load alone, and that the off-page address still reads zero afterwards. A second hard case is a strobe pulse issued during programming. After `busy` falls, the bench waits longer than a full window to prove that no new page was opened.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pcc_state_e;
endpackage

// File: rtl/pcc_strobe_sync.sv
module pcc_strobe_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '1;
            else        stage_q[g] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '1;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pcc_down_timer.sv
module pcc_down_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic [W-1:0] count,
   output logic         last
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign count = cnt_q;
   assign last  = (cnt_q == W'(1));
endmodule

// File: rtl/pcc_page_buffer.sv
module pcc_page_buffer #(
   parameter int PAGE_BYTES = 128,
   parameter int DATA_W     = 8,
   localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clear,
   input  logic [OFF_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0]     bytes_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      valid_q <= '0;
      else if (clear)  valid_q <= '0;
      else if (wr_en)  valid_q[wr_off] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) bytes_q[wr_off] <= wr_data;
   end

   assign rd_data  = bytes_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int PAGE_BYTES  = 128,
   parameter int ARRAY_BYTES = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int WINDOW_CYC  = 5000,
   parameter int PROG_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy
);
   import pcc_pkg::*;

   localparam int OFF_W  = $clog2(PAGE_BYTES);
   localparam int PAGE_W = ADDR_W - OFF_W;
   localparam int IDX_W  = $clog2(ARRAY_BYTES);
   localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
   localparam int PRG_W  = $clog2(PROG_CYCLES + 1);
   localparam int WALK_W = OFF_W + 1;

   // elaboration-time parameter checks
   if ((1 << OFF_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << IDX_W) != ARRAY_BYTES || ARRAY_BYTES < PAGE_BYTES) begin : g_bad_array
      $error("ARRAY_BYTES must be a power of two no smaller than a page");
   end
   if (IDX_W > ADDR_W) begin : g_bad_addr
      $error("ARRAY_BYTES exceeds the address space");
   end
   if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
      $error("PROG_CYCLES must cover one cycle per page byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least two");
   end
   if (WINDOW_CYC < 2) begin : g_bad_win
      $error("WINDOW_CYC must be at least two");
   end

   // strobe synchronisation and edge detection
   logic ce_s, oe_s, we_s;
   pcc_strobe_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ce_n, oe_n, we_n}),
      .sync_out ({ce_s, oe_s, we_s})
   );

   logic wr_act, wr_act_q, wr_pulse, rd_act;
   assign wr_act   = !ce_s && !we_s && oe_s;
   assign rd_act   = !ce_s && !oe_s && we_s;
   assign wr_pulse = wr_act && !wr_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_act_q <= 1'b0;
      else        wr_act_q <= wr_act;
   end

   // page tracking and load acceptance
   pcc_state_e        state_q;
   logic [PAGE_W-1:0] cur_page_q;
   logic [PAGE_W-1:0] pg_in;
   logic [OFF_W-1:0]  off_in;
   logic              in_load, load_acc, win_expire, prog_done;

   assign pg_in    = addr[ADDR_W-1:OFF_W];
   assign off_in   = addr[OFF_W-1:0];
   assign in_load  = (state_q == ST_LOAD);
   assign busy     = (state_q == ST_PROG);
   assign load_acc = wr_pulse &&
                     ((state_q == ST_IDLE) || (in_load && pg_in == cur_page_q));

   // byte-load window
   logic [WIN_W-1:0] win_cnt;
   logic             win_last;
   pcc_down_timer #(.W(WIN_W)) i_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_acc),
      .load_val (WIN_W'(WINDOW_CYC)),
      .tick     (in_load),
      .count    (win_cnt),
      .last     (win_last)
   );
   assign win_expire = in_load && win_last && !load_acc;

   // programming time
   logic [PRG_W-1:0] prg_cnt;
   logic             prg_last;
   pcc_down_timer #(.W(PRG_W)) i_prog (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (win_expire),
      .load_val (PRG_W'(PROG_CYCLES)),
      .tick     (busy),
      .count    (prg_cnt),
      .last     (prg_last)
   );
   assign prog_done = busy && prg_last;

   // page buffer
   logic [WALK_W-1:0] walk_q;
   logic [DATA_W-1:0] buf_data;
   logic              buf_valid, walk_active;

   pcc_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) i_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (load_acc),
      .wr_off   (off_in),
      .wr_data  (wdata),
      .clear    (prog_done),
      .rd_idx   (walk_q[OFF_W-1:0]),
      .rd_data  (buf_data),
      .rd_valid (buf_valid)
   );

   assign walk_active = busy && (walk_q < WALK_W'(PAGE_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           walk_q <= '0;
      else if (win_expire)  walk_q <= '0;
      else if (walk_active) walk_q <= walk_q + 1'b1;
   end

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cur_page_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (load_acc) begin
               state_q    <= ST_LOAD;
               cur_page_q <= pg_in;
            end
            ST_LOAD: if (win_expire) state_q <= ST_PROG;
            ST_PROG: if (prog_done)  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // behavioural array
   logic [ADDR_W-1:0] commit_addr;
   logic [IDX_W-1:0]  commit_idx;
   logic [DATA_W-1:0] mem [ARRAY_BYTES];

   assign commit_addr = {cur_page_q, walk_q[OFF_W-1:0]};
   assign commit_idx  = commit_addr[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= '0;
      end else if (walk_active && buf_valid) begin
         mem[commit_idx] <= buf_data;
      end
   end

   assign rdata = rd_act ? mem[addr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
   parameter int ADDR_W      = 16,
   parameter int PAGE_BYTES  = 128,
   parameter int WINDOW_CYC  = 5000,
   parameter int PROG_CYCLES = 500000,
   localparam int OFF_W      = $clog2(PAGE_BYTES),
   localparam int PAGE_W     = ADDR_W - OFF_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              load_acc,
   input logic              in_load,
   input logic [PAGE_W-1:0] cur_page,
   input logic [ADDR_W-1:0] addr
);
   logic [31:0] gap_q, busy_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   gap_q <= '0;
      else if (load_acc)            gap_q <= '0;
      else if (gap_q != '1)         gap_q <= gap_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run_q <= '0;
      else if (busy) busy_run_q <= busy_run_q + 1'b1;
      else           busy_run_q <= '0;
   end

   p_same_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_acc && in_load) |-> (addr[ADDR_W-1:OFF_W] == cur_page));

   p_commit_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (gap_q == 32'(WINDOW_CYC)));

   p_prog_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run_q == 32'(PROG_CYCLES)));

   p_no_load_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load_acc);
endmodule

bind page_commit_ctrl pcc_checker #(
   .ADDR_W      (ADDR_W),
   .PAGE_BYTES  (PAGE_BYTES),
   .WINDOW_CYC  (WINDOW_CYC),
   .PROG_CYCLES (PROG_CYCLES)
) i_pcc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .load_acc (load_acc),
   .in_load  (in_load),
   .cur_page (cur_page_q),
   .addr     (addr)
);

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
   localparam int CLK_T  = 10;
   localparam int SYNC   = 2;
   localparam int WIN    = 40;
   localparam int PRG    = 200;
   localparam int ABYTES = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_T/2) clk = ~clk;

   page_commit_ctrl #(
      .ARRAY_BYTES (ABYTES),
      .SYNC_STAGES (SYNC),
      .WINDOW_CYC  (WIN),
      .PROG_CYCLES (PRG)
   ) i_page_commit_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_byte(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic read_byte(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      d = rdata;
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
   endtask

   // load one byte and count falling edges until busy; optional off-page load mid-window
   task automatic timed_load(input logic [15:0] a, input logic [7:0] d,
                             input bit inject, input logic [15:0] oa,
                             input logic [7:0] od, output int n, output int blen);
      @(negedge clk);
      addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
      n = 0;
      for (int i = 0; i < 500; i++) begin
         @(negedge clk);
         n++;
         if (n == 4) begin we_n = 1'b1; ce_n = 1'b1; end
         if (inject && n == 10) begin addr = oa; wdata = od; ce_n = 1'b0; we_n = 1'b0; end
         if (inject && n == 14) begin we_n = 1'b1; ce_n = 1'b1; end
         if (busy) break;
      end
      blen = 1;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (!busy) break;
         blen++;
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R9 busy after reset", busy, 0);
      chk("R10 rdata idle strobes", rdata, 0);
      read_byte(16'h1234, v);
      chk("R9 array zero", v, 0);
   endtask

   task automatic t_single();
      int n, bl;
      logic [7:0] v;
      timed_load(16'h1234, 8'hA5, 1'b0, '0, '0, n, bl);
      chk("R5 commit edge", n, SYNC + WIN + 1);
      chk("R6 busy length", bl, PRG);
      read_byte(16'h1234, v);
      chk("R2 byte placed", v, 8'hA5);
      read_byte(16'h1235, v);
      chk("R8 neighbour untouched", v, 0);
   endtask

   task automatic t_page();
      logic [7:0] v;
      for (int k = 0; k < 10; k++) write_byte(16'h0080 + 16'(k), 8'h10 + 8'(k));
      write_byte(16'h0083, 8'hC3);
      chk("R4 busy low in long phase", busy, 0);
      for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
      chk("R5 commit after phase", busy, 1);
      wait_idle();
      read_byte(16'h0080, v); chk("R2 page byte 0", v, 8'h10);
      read_byte(16'h0089, v); chk("R4 page byte 9", v, 8'h19);
      read_byte(16'h0083, v); chk("R11 last value wins", v, 8'hC3);
      read_byte(16'h008A, v); chk("R8 unloaded offset", v, 0);
   endtask

   task automatic t_offpage();
      int n, bl;
      logic [7:0] v;
      timed_load(16'h0100, 8'h11, 1'b1, 16'h0200, 8'h22, n, bl);
      chk("R3 window not restarted", n, SYNC + WIN + 1);
      read_byte(16'h0101 - 16'h0001, v); chk("R3 first page byte", v, 8'h11);
      read_byte(16'h0200, v); chk("R3 off-page discarded", v, 0);
   endtask

   task automatic t_inhibit();
      logic [7:0] v;
      @(negedge clk);
      addr = 16'h0300; wdata = 8'h33; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      repeat (WIN + 20) @(negedge clk);
      chk("R1 no commit when inhibited", busy, 0);
      read_byte(16'h0300, v);
      chk("R1 inhibited byte not stored", v, 0);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] v;
      write_byte(16'h0040, 8'h44);
      for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
      chk("R7 reached busy", busy, 1);
      write_byte(16'h0041, 8'h55);
      wait_idle();
      repeat (WIN + 10) @(negedge clk);
      chk("R7 no new page after busy", busy, 0);
      read_byte(16'h0041, v); chk("R7 busy write dropped", v, 0);
      read_byte(16'h0040, v); chk("R2 pre-busy byte kept", v, 8'h44);
   endtask

   task automatic t_read_gate();
      @(negedge clk);
      addr = 16'h1234; ce_n = 1'b0; oe_n = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      chk("R10 rdata zero without output enable", rdata, 0);
      oe_n = 1'b0;
      repeat (SYNC + 1) @(negedge clk);
      chk("R10 rdata during read", rdata, 8'hA5);
      ce_n = 1'b1; oe_n = 1'b1;
      repeat (SYNC + 1) @(negedge clk);
      chk("R10 rdata zero after read", rdata, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_single();
      t_page();
      t_offpage();
      t_inhibit();
      t_busy_ignore();
      t_read_gate();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule